// File: doc/BRIEF.md
# Output-Stage Protection Supervisor

This block watches over a power stage made of four half-bridges, wired as two bridge pairs. Its inputs come from analog comparators whose thresholds and hysteresis are set outside the block, so each input is a single bit. There is one overcurrent bit per bridge pair. Each monitored supply has a "fell below" bit and a "rose above" bit. Temperature has set and release bits for both the warning level and the error level, and there is one overvoltage bit. The block also receives a one-clock pulse at the start of every PWM period.

When an overcurrent is seen, the block first limits current on a cycle-by-cycle basis. It counts the PWM periods that contain a limit event. If the overload lasts long enough, it latches a shutdown that puts every bridge into high impedance. It releases that latch only after the overcurrent input has stayed quiet for a programmable number of PWM periods. Thermal error, undervoltage on any supply and overvoltage also force the shutdown, but those clear by themselves. An active-low fault pin follows the shutdown. A sticky status bit keeps a record that a shutdown happened until software clears it.

Top module: `pstage_fault_ctrl`

## Requirements
- R1: After reset, ilim_cmd is 0, bridge_hiz is 0, fault_n is 1, therm_warn is 0 and fault_sticky is 0. Reset also clears the overload counter.
- R2: ilim_cmd[p] goes high in the cycle after oc_det[p] is high. It then holds until a pwm_tick edge at which oc_det[p] is low; at a pwm_tick edge it takes the value of oc_det[p].
- R3: An 8-bit counter advances once per PWM period in which any limit event occurred. When it reaches OL_TRIP (default 242, about 0.63 ms at 384 kHz), bridge_hiz latches high at that tick.
- R4: Sixteen consecutive PWM periods with no limit event return the counter to zero. A gap of 15 quiet periods does not.
- R5: An overload on either bridge pair drives the single bridge_hiz output, which covers all four half-bridges.
- R6: A latched overload releases at the tick that completes release_ticks consecutive quiet PWM periods (a value of 0 counts as 1). Any limit event while latched restarts that count.
- R7: therm_warn sets the cycle after tmp_warn_hi and clears the cycle after tmp_warn_lo; set wins when both are high. The warning alone never causes a shutdown.
- R8: tmp_err_hi forces bridge_hiz from the next cycle. The shutdown recovers by itself the cycle after tmp_err_lo.
- R9: Each supply bit of uv_fall sets its own undervoltage state and the matching uv_rise bit clears it. Any supply in undervoltage forces bridge_hiz.
- R10: ov_det forces a shutdown from the next cycle while it stays high, and the shutdown ends the cycle after ov_det falls.
- R11: fault_n is low exactly when bridge_hiz is high, and it returns high when the last cause clears.
- R12: fault_sticky sets the cycle after any shutdown and keeps its value after the shutdown ends. sticky_clr clears it, except when a shutdown is active: then the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwm_tick | input | 1 | One-clock pulse at each PWM period start |
| oc_det | input | NUM_PAIRS (2) | Overcurrent comparator, one bit per bridge pair |
| uv_fall | input | NUM_SUPPLIES (3) | Supply fell below its trip level |
| uv_rise | input | NUM_SUPPLIES (3) | Supply rose above its release level |
| ov_det | input | 1 | Overvoltage comparator |
| tmp_warn_hi | input | 1 | Temperature above the warning level |
| tmp_warn_lo | input | 1 | Temperature below the warning release level |
| tmp_err_hi | input | 1 | Temperature above the shutdown level |
| tmp_err_lo | input | 1 | Temperature below the shutdown release level |
| release_ticks | input | REL_W (8) | Quiet PWM periods needed to release an overload latch |
| sticky_clr | input | 1 | Software clear of the sticky status bit |
| ilim_cmd | output | NUM_PAIRS (2) | Cycle-by-cycle current-limit command per pair |
| bridge_hiz | output | 1 | Tristate command for all four half-bridges |
| fault_n | output | 1 | Active-low fault indicator |
| therm_warn | output | 1 | Over-temperature warning |
| fault_sticky | output | 1 | Sticky record of a shutdown |

## Verification
The hardest state to reach from the ports is a counter that sits one period short of the trip after a long intermittent overload. A second hard point is the exact quiet-gap length that wipes the counter.

The bench drives patterns of one limited PWM period followed by 15 or 16 quiet periods, hundreds of times over. It shows that the 16-period gap never trips. It shows that the 15-period gap trips on exactly the 242nd limited period. The latch release is tested the same way: a single limit event is placed inside the quiet window, and the bench checks that this restarts the count.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned DEF_PAIRS    = 2;
  localparam int unsigned DEF_SUPPLIES = 3;
  localparam int unsigned DEF_CNT_W    = 8;
  localparam int unsigned DEF_OL_TRIP  = 242;
  localparam int unsigned DEF_QUIET    = 16;
  localparam int unsigned DEF_REL_W    = 8;

  typedef struct packed {
    logic ovp;
    logic uvp;
    logic ote;
    logic olp;
  } trip_t;
endpackage

// File: rtl/pfs_hyst.sv
module pfs_hyst #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] state_o
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st_q <= 1'b0;
        else if (set_i[i]) st_q <= 1'b1;
        else if (clr_i[i]) st_q <= 1'b0;
      end
      assign state_o[i] = st_q;
    end
  endgenerate
endmodule

// File: rtl/pfs_cbc_limit.sv
module pfs_cbc_limit #(
  parameter int unsigned PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_tick,
  input  logic [PAIRS-1:0] oc_i,
  output logic [PAIRS-1:0] ilim_o,
  output logic             cyc_hit_o
);
  logic hit_q;

  genvar p;
  generate
    for (p = 0; p < PAIRS; p++) begin : g_pair
      logic lim_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lim_q <= 1'b0;
        else if (oc_i[p])  lim_q <= 1'b1;
        else if (pwm_tick) lim_q <= 1'b0;
      end
      assign ilim_o[p] = lim_q;
    end
  endgenerate

  // Remembers any limit event inside the current PWM period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hit_q <= 1'b0;
    else if (pwm_tick) hit_q <= 1'b0;
    else if (|oc_i)    hit_q <= 1'b1;
  end

  assign cyc_hit_o = hit_q | (|oc_i);
endmodule

// File: rtl/pfs_overload.sv
module pfs_overload #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned OL_TRIP = 242,
  parameter int unsigned QUIET   = 16,
  parameter int unsigned REL_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_tick,
  input  logic             cyc_hit,
  input  logic [REL_W-1:0] release_ticks,
  output logic             latched_o
);
  localparam int unsigned QW = (QUIET > 2) ? $clog2(QUIET) : 1;
  localparam logic [CNT_W-1:0] TRIP_V  = CNT_W'(OL_TRIP);
  localparam logic [QW-1:0]    QLAST_V = QW'(QUIET - 1);

  logic [CNT_W-1:0] ol_cnt, ol_inc;
  logic [QW-1:0]    quiet_q;
  logic [REL_W-1:0] rel_q;
  logic [REL_W:0]   rel_next, rel_goal;
  logic             latched_q;

  assign ol_inc   = (ol_cnt == '1) ? ol_cnt : ol_cnt + 1'b1;
  assign rel_next = {1'b0, rel_q} + 1'b1;
  assign rel_goal = (release_ticks == '0) ? (REL_W+1)'(1) : {1'b0, release_ticks};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ol_cnt    <= '0;
      quiet_q   <= '0;
      rel_q     <= '0;
      latched_q <= 1'b0;
    end else if (pwm_tick) begin
      if (latched_q) begin
        if (cyc_hit) begin
          rel_q <= '0;
        end else if (rel_next >= rel_goal) begin
          latched_q <= 1'b0;
          rel_q     <= '0;
          ol_cnt    <= '0;
          quiet_q   <= '0;
        end else begin
          rel_q <= rel_next[REL_W-1:0];
        end
      end else if (cyc_hit) begin
        quiet_q <= '0;
        ol_cnt  <= ol_inc;
        if (ol_inc >= TRIP_V) begin
          latched_q <= 1'b1;
          rel_q     <= '0;
        end
      end else if (quiet_q == QLAST_V) begin
        quiet_q <= '0;
        ol_cnt  <= '0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

  assign latched_o = latched_q;
endmodule

// File: rtl/pfs_status.sv
module pfs_status
  import pfs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trip_t trips,
  input  logic  sticky_clr,
  output logic  shutdown_o,
  output logic  sticky_o
);
  logic sticky_q;

  assign shutdown_o = |trips;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sticky_q <= 1'b0;
    else if (shutdown_o) sticky_q <= 1'b1;
    else if (sticky_clr) sticky_q <= 1'b0;
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/pstage_fault_ctrl.sv
module pstage_fault_ctrl
  import pfs_pkg::*;
#(
  parameter int unsigned NUM_PAIRS    = DEF_PAIRS,
  parameter int unsigned NUM_SUPPLIES = DEF_SUPPLIES,
  parameter int unsigned CNT_W        = DEF_CNT_W,
  parameter int unsigned OL_TRIP      = DEF_OL_TRIP,
  parameter int unsigned QUIET        = DEF_QUIET,
  parameter int unsigned REL_W        = DEF_REL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwm_tick,
  input  logic [NUM_PAIRS-1:0]    oc_det,
  input  logic [NUM_SUPPLIES-1:0] uv_fall,
  input  logic [NUM_SUPPLIES-1:0] uv_rise,
  input  logic                    ov_det,
  input  logic                    tmp_warn_hi,
  input  logic                    tmp_warn_lo,
  input  logic                    tmp_err_hi,
  input  logic                    tmp_err_lo,
  input  logic [REL_W-1:0]        release_ticks,
  input  logic                    sticky_clr,
  output logic [NUM_PAIRS-1:0]    ilim_cmd,
  output logic                    bridge_hiz,
  output logic                    fault_n,
  output logic                    therm_warn,
  output logic                    fault_sticky
);
  logic                    cyc_hit, olp_latched, ote_state, ov_q, shutdown;
  logic [NUM_SUPPLIES-1:0] uv_state;
  trip_t                   trips;

  pfs_cbc_limit #(.PAIRS(NUM_PAIRS)) u_cbc (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .oc_i(oc_det),
    .ilim_o(ilim_cmd), .cyc_hit_o(cyc_hit)
  );

  pfs_overload #(.CNT_W(CNT_W), .OL_TRIP(OL_TRIP), .QUIET(QUIET), .REL_W(REL_W)) u_olp (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .cyc_hit(cyc_hit),
    .release_ticks(release_ticks), .latched_o(olp_latched)
  );

  pfs_hyst #(.W(1)) u_warn (
    .clk(clk), .rst_n(rst_n), .set_i(tmp_warn_hi), .clr_i(tmp_warn_lo), .state_o(therm_warn)
  );

  pfs_hyst #(.W(1)) u_ote (
    .clk(clk), .rst_n(rst_n), .set_i(tmp_err_hi), .clr_i(tmp_err_lo), .state_o(ote_state)
  );

  pfs_hyst #(.W(NUM_SUPPLIES)) u_uvp (
    .clk(clk), .rst_n(rst_n), .set_i(uv_fall), .clr_i(uv_rise), .state_o(uv_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_det;
  end

  always_comb begin
    trips.olp = olp_latched;
    trips.ote = ote_state;
    trips.uvp = |uv_state;
    trips.ovp = ov_q;
  end

  pfs_status u_stat (
    .clk(clk), .rst_n(rst_n), .trips(trips), .sticky_clr(sticky_clr),
    .shutdown_o(shutdown), .sticky_o(fault_sticky)
  );

  assign bridge_hiz = shutdown;
  assign fault_n    = ~shutdown;
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk #(
  parameter int unsigned NUM_PAIRS    = 2,
  parameter int unsigned NUM_SUPPLIES = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pwm_tick,
  input logic [NUM_PAIRS-1:0]    oc_det,
  input logic [NUM_SUPPLIES-1:0] uv_fall,
  input logic                    ov_det,
  input logic                    tmp_warn_hi,
  input logic                    tmp_warn_lo,
  input logic                    tmp_err_hi,
  input logic [NUM_PAIRS-1:0]    ilim_cmd,
  input logic                    bridge_hiz,
  input logic                    fault_n,
  input logic                    therm_warn,
  input logic                    fault_sticky
);
  AST_ILIM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_det) |=> ((ilim_cmd & $past(oc_det)) == $past(oc_det))); // R2
  AST_ILIM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_tick |=> (ilim_cmd == $past(oc_det))); // R2
  AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_warn_hi |=> therm_warn); // R7
  AST_WARN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_warn_lo && !tmp_warn_hi) |=> !therm_warn); // R7
  AST_OTE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_err_hi |=> bridge_hiz); // R8
  AST_UV_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (|uv_fall) |=> bridge_hiz); // R9
  AST_OV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ov_det |=> !fault_n); // R10
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |=> fault_sticky); // R12
endmodule

bind pstage_fault_ctrl pfs_chk #(.NUM_PAIRS(NUM_PAIRS), .NUM_SUPPLIES(NUM_SUPPLIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .oc_det(oc_det), .uv_fall(uv_fall),
  .ov_det(ov_det), .tmp_warn_hi(tmp_warn_hi), .tmp_warn_lo(tmp_warn_lo),
  .tmp_err_hi(tmp_err_hi), .ilim_cmd(ilim_cmd), .bridge_hiz(bridge_hiz),
  .fault_n(fault_n), .therm_warn(therm_warn), .fault_sticky(fault_sticky)
);

// File: tb/pstage_fault_ctrl_tb.sv
module pstage_fault_ctrl_tb;
  localparam int PAIRS = 2;
  localparam int SUP   = 3;
  localparam int TRIP  = 242;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwm_tick = 1'b0;
  logic [PAIRS-1:0] oc_det = '0;
  logic [SUP-1:0]   uv_fall = '0, uv_rise = '0;
  logic             ov_det = 1'b0;
  logic             tmp_warn_hi = 1'b0, tmp_warn_lo = 1'b0;
  logic             tmp_err_hi = 1'b0, tmp_err_lo = 1'b0;
  logic [7:0]       release_ticks = 8'd5;
  logic             sticky_clr = 1'b0;
  logic [PAIRS-1:0] ilim_cmd;
  logic             bridge_hiz, fault_n, therm_warn, fault_sticky;
  int               n_cmp = 0, n_bad = 0;
  logic             done = 1'b0;

  always #2 clk = ~clk;

  pstage_fault_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .oc_det(oc_det),
    .uv_fall(uv_fall), .uv_rise(uv_rise), .ov_det(ov_det),
    .tmp_warn_hi(tmp_warn_hi), .tmp_warn_lo(tmp_warn_lo),
    .tmp_err_hi(tmp_err_hi), .tmp_err_lo(tmp_err_lo),
    .release_ticks(release_ticks), .sticky_clr(sticky_clr),
    .ilim_cmd(ilim_cmd), .bridge_hiz(bridge_hiz), .fault_n(fault_n),
    .therm_warn(therm_warn), .fault_sticky(fault_sticky)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pwm_period();
    @(negedge clk) pwm_tick = 1'b1;
    @(negedge clk) pwm_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; oc_det = '0; uv_fall = '0; uv_rise = '0; ov_det = 1'b0;
    tmp_warn_hi = 0; tmp_warn_lo = 0; tmp_err_hi = 0; tmp_err_lo = 0;
    sticky_clr = 0; pwm_tick = 0; release_ticks = 8'd5;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ilim", ilim_cmd, 0);
    chk("R1 hiz", bridge_hiz, 0);
    chk("R1 fault_n", fault_n, 1);
    chk("R1 warn", therm_warn, 0);
    chk("R1 sticky", fault_sticky, 0);
  endtask

  task automatic t_cbc();
    do_reset();
    oc_det = 2'b01; step(); oc_det = '0;
    chk("R2 ilim set", ilim_cmd, 2'b01);
    repeat (3) step();
    chk("R2 ilim hold", ilim_cmd, 2'b01);
    chk("R2 no shutdown", bridge_hiz, 0);
    pwm_period();
    chk("R2 ilim cleared at tick", ilim_cmd, 2'b00);
    oc_det = 2'b10; pwm_period(); oc_det = '0;
    chk("R2 ilim carried over tick", ilim_cmd, 2'b10);
    pwm_period();
    chk("R2 ilim drops", ilim_cmd, 2'b00);
  endtask

  task automatic t_overload(input int pair);
    do_reset();
    oc_det = PAIRS'(1) << pair;
    repeat (TRIP - 1) pwm_period();
    chk("R3 one short of trip", bridge_hiz, 0);
    pwm_period();
    chk("R3 trip", bridge_hiz, 1);
    chk("R5 fault_n on pair trip", fault_n, 0);
    oc_det = '0;
    repeat (3) pwm_period();
    oc_det = PAIRS'(1) << pair; pwm_period(); oc_det = '0;
    repeat (4) pwm_period();
    chk("R6 hit restarted release", bridge_hiz, 1);
    pwm_period();
    chk("R6 released", bridge_hiz, 0);
    chk("R11 fault_n back", fault_n, 1);
    chk("R12 sticky kept", fault_sticky, 1);
  endtask

  task automatic t_quiet_gap();
    do_reset();
    repeat (TRIP + 20) begin
      oc_det = 2'b01; pwm_period(); oc_det = '0;
      repeat (16) pwm_period();
    end
    chk("R4 gap 16 never trips", bridge_hiz, 0);
    repeat (TRIP - 1) begin
      oc_det = 2'b01; pwm_period(); oc_det = '0;
      repeat (15) pwm_period();
    end
    chk("R4 gap 15 accumulates, not yet", bridge_hiz, 0);
    oc_det = 2'b01; pwm_period(); oc_det = '0;
    chk("R4 gap 15 trips", bridge_hiz, 1);
  endtask

  task automatic t_thermal();
    do_reset();
    tmp_warn_hi = 1; step(); tmp_warn_hi = 0;
    chk("R7 warn set", therm_warn, 1);
    chk("R7 warn no shutdown", bridge_hiz, 0);
    repeat (2) step();
    chk("R7 warn held", therm_warn, 1);
    tmp_warn_hi = 1; tmp_warn_lo = 1; step(); tmp_warn_hi = 0;
    chk("R7 set wins", therm_warn, 1);
    step(); tmp_warn_lo = 0;
    chk("R7 warn clears", therm_warn, 0);
    tmp_err_hi = 1; step(); tmp_err_hi = 0;
    chk("R8 ote hiz", bridge_hiz, 1);
    chk("R11 ote fault_n", fault_n, 0);
    repeat (3) step();
    chk("R8 ote held", bridge_hiz, 1);
    tmp_err_lo = 1; step(); tmp_err_lo = 0;
    chk("R8 ote recovered", bridge_hiz, 0);
    chk("R12 sticky after ote", fault_sticky, 1);
    sticky_clr = 1; step(); sticky_clr = 0;
    chk("R12 sticky cleared", fault_sticky, 0);
  endtask

  task automatic t_uv();
    do_reset();
    uv_fall = 3'b010; step(); uv_fall = '0;
    chk("R9 uv trip", bridge_hiz, 1);
    uv_fall = 3'b001; step(); uv_fall = '0;
    uv_rise = 3'b010; step(); uv_rise = '0;
    chk("R9 other supply holds", bridge_hiz, 1);
    uv_rise = 3'b001; step(); uv_rise = '0;
    chk("R9 uv release", bridge_hiz, 0);
  endtask

  task automatic t_ov();
    do_reset();
    ov_det = 1; step();
    chk("R10 ov fault", fault_n, 0);
    chk("R10 ov hiz", bridge_hiz, 1);
    sticky_clr = 1; step(); sticky_clr = 0;
    chk("R12 set wins over clear", fault_sticky, 1);
    ov_det = 0; step();
    chk("R10 ov released", fault_n, 1);
    chk("R12 sticky holds", fault_sticky, 1);
    sticky_clr = 1; step(); sticky_clr = 0;
    chk("R12 sticky cleared", fault_sticky, 0);
  endtask

  initial begin
    t_reset();
    t_cbc();
    t_overload(0);
    t_overload(1);
    t_quiet_gap();
    t_thermal();
    t_uv();
    t_ov();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule